// File: doc/BRIEF.md
# Execution Context Access Monitor

This block sits beside a soft CPU and watches every bus cycle to decide which execution context the CPU is in: firmware, application, or a system call in progress. After reset the CPU runs firmware out of an 8 KB ROM at address zero. The first instruction fetched from anywhere else moves the monitor into application mode, and it never goes back to firmware mode without a reset. Application code requests a service by writing anywhere in a reserved 16 MB window. The monitor answers with a one-cycle syscall interrupt request and enters the syscall context. The return-from-interrupt indication ends that context.

The context decides two permissions: whether code may execute from ROM, and whether the protected device identifier may be read. The monitor also checks every access against the ROM and firmware RAM limits and against a stack guard floor at the bottom of firmware RAM. An offending access is withheld from the bus, and it sets a trap flag that stays set until reset.

Top module: `exec_ctx_monitor`

## Requirements
- R1: After reset, `mode` is 0 (firmware), and `syscallIrq` and `trapFlag` are 0.
- R2: In firmware mode, a valid instruction fetch at an address of `ROM_BYTES` (8192) or more puts `mode` at 1 (application) from the next cycle on.
- R3: Once `mode` has left 0, it never returns to 0 before reset, whatever the bus does.
- R4: A valid write to an address from 0xE1000000 to 0xE1FFFFFF drives `syscallIrq` high for exactly the following cycle. Reads and fetches in that window do not.
- R5: Such a write made in application mode sets `mode` to 2 (syscall) in the next cycle. Made in firmware mode, it leaves `mode` at 0.
- R6: When `irqReturn` is high in syscall mode, `mode` is 1 in the next cycle. In any other mode, `irqReturn` has no effect.
- R7: An instruction fetch from the ROM range (address below 8192) is legal in modes 0 and 2. In mode 1 it is a violation.
- R8: `udiReadEn` is high only for a valid data read (write low, fetch low) within the identifier window 0xFF000008 to 0xFF00000F, and only while `mode` is not 1.
- R9: Any access whose top byte is 0x00 at an offset of 8192 or more, or whose top byte is 0xD0 at an offset of 4096 or more, is a violation.
- R10: Any access in the firmware RAM window (top byte 0xD0) below offset 0x100, the stack guard floor, is a violation.
- R11: A violation holds `busGrant` low in the same cycle and sets `trapFlag` from the next cycle until reset. Every other valid access has `busGrant` high.
- R12: An access in the same cycle as a mode change is judged against the mode held before that change. A ROM fetch together with `irqReturn` in syscall mode is legal. A syscall write together with `irqReturn` in syscall mode still raises `syscallIrq`, and the mode still returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | A bus access is presented this cycle |
| busAddr | input | 32 | Byte address of the access |
| busWrite | input | 1 | The access is a write |
| busInstr | input | 1 | The access is an instruction fetch |
| irqReturn | input | 1 | The CPU is returning from an interrupt |
| mode | output | 2 | Context: 0 firmware, 1 application, 2 syscall |
| syscallIrq | output | 1 | One-cycle syscall interrupt request |
| udiReadEn | output | 1 | Read of the device identifier is allowed |
| busGrant | output | 1 | The access is forwarded to the bus |
| trapFlag | output | 1 | Sticky violation flag |

## Verification
Two events can fall in the same cycle: a context exit and an access whose permission depends on that context. The bench provokes this in syscall mode, where `irqReturn` arrives together with a ROM fetch, and again together with a fresh write to the syscall window. It requires the fetch to be granted with no trap, the interrupt to pulse, and the mode to read 1 afterwards. The near-exhaustive sweep adds the cases where a fetch outside ROM changes the mode and also violates a range check in that same cycle.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

  typedef enum logic [1:0] {
    MODE_FW  = 2'd0,
    MODE_APP = 2'd1,
    MODE_SYS = 2'd2
  } ctxMode_t;

  // Events the datapath decodes from the bus for the control FSM.
  typedef struct packed {
    logic fetchOutside;
    logic sysWrite;
    logic retSeen;
  } busEvt_t;

  // Permissions the control FSM grants to the datapath.
  typedef struct packed {
    logic romExecOk;
    logic udiOk;
  } ctxStrobe_t;

endpackage

// File: rtl/ctx_datapath.sv
module ctx_datapath
  import ctx_pkg::*;
#(
  parameter int                  ADDR_W      = 32,
  parameter int                  APT_W       = 8,
  parameter int                  ROM_BYTES   = 8192,
  parameter logic [ADDR_W-1:0]   FWRAM_BASE  = 32'hD000_0000,
  parameter int                  FWRAM_BYTES = 4096,
  parameter int                  FWRAM_FLOOR = 256,
  parameter logic [APT_W-1:0]    SYS_APT     = 8'hE1,
  parameter logic [ADDR_W-1:0]   UDI_BASE    = 32'hFF00_0008,
  parameter int                  UDI_WORDS   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic              busInstr,
  input  logic              irqReturn,
  input  ctxStrobe_t        strobe,
  output busEvt_t           evt,
  output logic              syscallIrq,
  output logic              udiReadEn,
  output logic              busGrant,
  output logic              trapFlag
);

  localparam int               OFS_W     = ADDR_W - APT_W;
  localparam logic [OFS_W-1:0] ROM_LIMIT = OFS_W'(ROM_BYTES);
  localparam logic [OFS_W-1:0] FW_LIMIT  = OFS_W'(FWRAM_BYTES);
  localparam logic [OFS_W-1:0] FW_FLOOR  = OFS_W'(FWRAM_FLOOR);
  localparam logic [APT_W-1:0] FW_APT    = FWRAM_BASE[ADDR_W-1 -: APT_W];
  localparam logic [ADDR_W-1:0] UDI_LO   = UDI_BASE;
  localparam logic [ADDR_W-1:0] UDI_HI   = UDI_BASE + ADDR_W'(UDI_WORDS * 4);

  logic [APT_W-1:0] aptSel;
  logic [OFS_W-1:0] offs;
  logic romApt, romHit, fwApt, sysHit, udiHit;
  logic rangeErr, stackErr, execErr, violation;
  logic irqQ, trapQ;

  assign aptSel = busAddr[ADDR_W-1 -: APT_W];
  assign offs   = busAddr[OFS_W-1:0];

  // Region decode
  assign romApt = (aptSel == '0);
  assign romHit = romApt && (offs < ROM_LIMIT);
  assign fwApt  = (aptSel == FW_APT);
  assign sysHit = (aptSel == SYS_APT);
  assign udiHit = (busAddr >= UDI_LO) && (busAddr < UDI_HI);

  // Access checks
  assign rangeErr  = (romApt && !romHit) || (fwApt && (offs >= FW_LIMIT));
  assign stackErr  = fwApt && (offs < FW_FLOOR);
  assign execErr   = busInstr && romHit && !strobe.romExecOk;
  assign violation = busValid && (rangeErr || stackErr || execErr);

  assign busGrant  = busValid && !violation;
  assign udiReadEn = busValid && !busWrite && !busInstr && udiHit && strobe.udiOk;

  assign evt.fetchOutside = busValid && busInstr && !romHit;
  assign evt.sysWrite     = busValid && busWrite && sysHit;
  assign evt.retSeen      = irqReturn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqQ  <= 1'b0;
      trapQ <= 1'b0;
    end else begin
      irqQ  <= evt.sysWrite;
      trapQ <= trapQ || violation;
    end
  end

  assign syscallIrq = irqQ;
  assign trapFlag   = trapQ;

endmodule

// File: rtl/ctx_control.sv
module ctx_control
  import ctx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  busEvt_t    evt,
  output ctxMode_t   mode,
  output ctxStrobe_t strobe
);

  ctxMode_t modeQ, modeD;

  always_comb begin
    modeD = modeQ;
    unique case (modeQ)
      MODE_FW:  if (evt.fetchOutside) modeD = MODE_APP;
      MODE_APP: if (evt.sysWrite)     modeD = MODE_SYS;
      MODE_SYS: if (evt.retSeen)      modeD = MODE_APP;
      default:  modeD = MODE_APP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= MODE_FW;
    else       modeQ <= modeD;
  end

  assign mode             = modeQ;
  assign strobe.romExecOk = (modeQ == MODE_FW) || (modeQ == MODE_SYS);
  assign strobe.udiOk     = (modeQ != MODE_APP);

endmodule

// File: rtl/exec_ctx_monitor.sv
module exec_ctx_monitor
  import ctx_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter int                APT_W       = 8,
  parameter int                ROM_BYTES   = 8192,
  parameter logic [ADDR_W-1:0] FWRAM_BASE  = 32'hD000_0000,
  parameter int                FWRAM_BYTES = 4096,
  parameter int                FWRAM_FLOOR = 256,
  parameter logic [APT_W-1:0]  SYS_APT     = 8'hE1,
  parameter logic [ADDR_W-1:0] UDI_BASE    = 32'hFF00_0008,
  parameter int                UDI_WORDS   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic              busInstr,
  input  logic              irqReturn,
  output logic [1:0]        mode,
  output logic              syscallIrq,
  output logic              udiReadEn,
  output logic              busGrant,
  output logic              trapFlag
);

  busEvt_t    evt;
  ctxStrobe_t strobe;
  ctxMode_t   modeQ;

  ctx_datapath #(
    .ADDR_W(ADDR_W), .APT_W(APT_W), .ROM_BYTES(ROM_BYTES),
    .FWRAM_BASE(FWRAM_BASE), .FWRAM_BYTES(FWRAM_BYTES),
    .FWRAM_FLOOR(FWRAM_FLOOR), .SYS_APT(SYS_APT),
    .UDI_BASE(UDI_BASE), .UDI_WORDS(UDI_WORDS)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busAddr(busAddr),
    .busWrite(busWrite), .busInstr(busInstr), .irqReturn(irqReturn),
    .strobe(strobe), .evt(evt), .syscallIrq(syscallIrq),
    .udiReadEn(udiReadEn), .busGrant(busGrant), .trapFlag(trapFlag)
  );

  ctx_control i_control (
    .clk(clk), .rstN(rstN), .evt(evt), .mode(modeQ), .strobe(strobe)
  );

  assign mode = modeQ;

endmodule

// File: rtl/ctx_monitor_checker.sv
module ctx_monitor_checker #(
  parameter int               ADDR_W    = 32,
  parameter int               APT_W     = 8,
  parameter int               ROM_BYTES = 8192,
  parameter logic [APT_W-1:0] SYS_APT   = 8'hE1
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrite,
  input logic              busInstr,
  input logic              irqReturn,
  input logic [1:0]        mode,
  input logic              syscallIrq,
  input logic              udiReadEn,
  input logic              busGrant,
  input logic              trapFlag
);

  logic sysWin, romFetch;
  assign sysWin   = busValid && busWrite && (busAddr[ADDR_W-1 -: APT_W] == SYS_APT);
  assign romFetch = busValid && busInstr && (busAddr < ADDR_W'(ROM_BYTES));

  AST_FETCH_TO_APP: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0 && busValid && busInstr && !romFetch) |=> (mode == 2'd1)); // R2

  AST_APP_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (mode != 2'd0) |=> (mode != 2'd0)); // R3

  AST_SYSCALL_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    sysWin |=> syscallIrq); // R4

  AST_IRQ_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    !sysWin |=> !syscallIrq); // R4

  AST_ENTER_SYS: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd1 && sysWin) |=> (mode == 2'd2)); // R5

  AST_SYS_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd2 && irqReturn) |=> (mode == 2'd1)); // R6

  AST_APP_ROM_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd1 && romFetch) |-> !busGrant); // R7

  AST_UDI_APP: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd1) |-> !udiReadEn); // R8

  AST_TRAP_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    trapFlag |=> trapFlag); // R11

  AST_DENY_TRAPS: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busGrant) |=> trapFlag); // R11

endmodule

bind exec_ctx_monitor ctx_monitor_checker #(
  .ADDR_W(ADDR_W), .APT_W(APT_W), .ROM_BYTES(ROM_BYTES), .SYS_APT(SYS_APT)
) i_checker (.*);

// File: tb/test_exec_ctx_monitor.sv
`timescale 1ns/1ps
module test_exec_ctx_monitor;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic [31:0] busAddr = '0;
  logic        busWrite = 1'b0;
  logic        busInstr = 1'b0;
  logic        irqReturn = 1'b0;
  logic [1:0]  mode;
  logic        syscallIrq, udiReadEn, busGrant, trapFlag;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;
  int mMode   = 0;
  bit mTrap   = 0;

  localparam logic [31:0] ADDRS [18] = '{
    32'h0000_0000, 32'h0000_1FFC, 32'h0000_2000, 32'h00FF_FFFC,
    32'hD000_0000, 32'hD000_00FC, 32'hD000_0100, 32'hD000_0FFC,
    32'hD000_1000, 32'hFF00_0004, 32'hFF00_0008, 32'hFF00_000C,
    32'hFF00_0010, 32'hE100_0000, 32'hE1FF_FFFC, 32'hE200_0000,
    32'hE0FF_FFFC, 32'h4000_0000};

  always #2.5 clk = ~clk;

  exec_ctx_monitor i_exec_ctx_monitor (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busAddr(busAddr),
    .busWrite(busWrite), .busInstr(busInstr), .irqReturn(irqReturn),
    .mode(mode), .syscallIrq(syscallIrq), .udiReadEn(udiReadEn),
    .busGrant(busGrant), .trapFlag(trapFlag)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // 0 none, 1 range (R9), 2 stack floor (R10), 3 ROM execute (R7)
  function automatic int violKind(logic [31:0] a, int kind, int md);
    logic [7:0]  apt = a[31:24];
    logic [23:0] off = a[23:0];
    if (apt == 8'h00 && off >= 24'h2000) return 1;
    if (apt == 8'hD0 && off >= 24'h1000) return 1;
    if (apt == 8'hD0 && off <  24'h100)  return 2;
    if (kind == 2 && apt == 8'h00 && md == 1) return 3;
    return 0;
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; busValid = 0; busWrite = 0; busInstr = 0; irqReturn = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    mMode = 0; mTrap = 0;
    #1;
    check("R1", "mode", mode, 0);
    check("R1", "syscallIrq", syscallIrq, 0);
    check("R1", "trapFlag", trapFlag, 0);
  endtask

  // kind: 0 read, 1 write, 2 fetch. Called at a falling edge.
  task automatic step(logic [31:0] a, int kind, bit ret, string tagOvr);
    int    vk;
    bit    expUdi, sysW, romHit;
    int    nextMode;
    string gTag, mTag;
    busValid = 1; busAddr = a; busWrite = (kind == 1); busInstr = (kind == 2);
    irqReturn = ret;
    vk     = violKind(a, kind, mMode);
    romHit = (a < 32'h2000);
    sysW   = (kind == 1) && (a[31:24] == 8'hE1);
    expUdi = (kind == 0) && (a >= 32'hFF00_0008) && (a < 32'hFF00_0010) && (mMode != 1);
    gTag   = (vk == 1) ? "R9" : (vk == 2) ? "R10" : (vk == 3) ? "R7" : "R11";
    nextMode = mMode;
    mTag = "R3";
    if (mMode == 0) begin
      mTag = sysW ? "R5" : "R2";
      if (kind == 2 && !romHit) nextMode = 1;
    end else if (mMode == 1) begin
      mTag = sysW ? "R5" : (ret ? "R6" : "R3");
      if (sysW) nextMode = 2;
    end else begin
      mTag = "R6";
      if (ret) nextMode = 1;
    end
    if (tagOvr != "") begin gTag = tagOvr; mTag = tagOvr; end
    #1;
    check(gTag, "busGrant", busGrant, (vk == 0));
    check(tagOvr != "" ? tagOvr : "R8", "udiReadEn", udiReadEn, expUdi);
    @(posedge clk);
    #1;
    busValid = 0; busWrite = 0; busInstr = 0; irqReturn = 0;
    mTrap = mTrap || (vk != 0);
    mMode = nextMode;
    @(negedge clk);
    check(mTag, "mode", mode, mMode);
    check(tagOvr != "" ? tagOvr : "R4", "syscallIrq", syscallIrq, sysW);
    check(tagOvr != "" ? tagOvr : "R11", "trapFlag", trapFlag, mTrap);
  endtask

  task automatic enter(int target);
    doReset();
    if (target >= 1) step(32'h4000_0000, 2, 0, "");
    if (target >= 2) step(32'hE100_0000, 1, 0, "");
  endtask

  initial begin
    // Near-exhaustive sweep: every mode x access kind x address
    for (int m = 0; m < 3; m++)
      for (int k = 0; k < 3; k++)
        for (int i = 0; i < 18; i++) begin
          enter(m);
          step(ADDRS[i], k, 0, "");
        end

    // R6: irqReturn outside syscall mode is ignored
    enter(0);
    step(32'h0000_0100, 0, 1, "");
    enter(1);
    step(32'hD000_0200, 0, 1, "");
    step(32'h0000_0040, 0, 0, "");

    // R3: application mode survives a long mixed sequence
    enter(2);
    step(32'h0000_0000, 2, 1, "R12");
    step(32'hE100_0010, 1, 0, "");
    step(32'hE100_0020, 1, 1, "R12");
    step(32'h0000_0000, 2, 0, "");
    step(32'h0000_0000, 2, 0, "");
    step(32'h4000_0100, 2, 1, "");
    check("R3", "final mode", mode, 1);
    check("R11", "sticky trap", trapFlag, 1);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule